// File: doc/BRIEF.md
# Variable-Length Instruction Field Decoder

This block parses a window of instruction bytes taken from the current program counter into the fields of one instruction. The instruction set has 32-bit words and instructions of 1, 2, 5 or 6 bytes. The upper nibble of the first byte selects the instruction class, and that class alone sets the length. The block returns the class code and the function code, two 4-bit register specifiers, a 32-bit constant, the length, the next-sequential program counter and a flag that marks an unknown class.

The logic is purely combinational. A fetch stage places the six bytes starting at the program counter on `win_i`, with byte k on bits [8k+7:8k]. It reads the decoded fields in the same cycle. Operand reads, memory access and the choice between the sequential and a branch address all sit outside this block.

Top module: `instr_fetch_decode`

## Requirements
- R1: `op_class_o` equals byte 0 bits [7:4] and `op_func_o` equals byte 0 bits [3:0], for every class code.
- R2: `len_o` is 1 for class codes 0x0, 0x1 and 0x9. It is 2 for 0x2, 0x6, 0xA and 0xB. It is 5 for 0x7 and 0x8, and 6 for 0x3, 0x4 and 0x5.
- R3: `next_pc_o` equals `pc_i + len_o` modulo 2^32, including when the sum wraps past 0xFFFFFFFF.
- R4: For class codes 0x2 to 0x6, 0xA and 0xB, `reg_a_o` is byte 1 bits [7:4] and `reg_b_o` is byte 1 bits [3:0]. The bytes are passed through as they are, so a 0xF written in the byte appears at the output unchanged.
- R5: For class codes 0x0, 0x1, 0x7, 0x8 and 0x9, both `reg_a_o` and `reg_b_o` are 0xF, which means no register, whatever byte 1 holds.
- R6: For class codes 0x3, 0x4 and 0x5, `imm_o` is bytes 2 to 5 taken little-endian, with byte 2 as the least significant. For example, the bytes 30 F2 cd ab 00 00 give `imm_o`=0x0000abcd and `reg_b_o`=2.
- R7: For class codes 0x7 and 0x8, `imm_o` is bytes 1 to 4 taken little-endian, with byte 1 as the least significant.
- R8: For every class that carries no constant, `imm_o` is 0. This holds whatever the other bytes of the window hold.
- R9: For class codes 0xC to 0xF, `valid_o` is 0, `len_o` is 1, both register outputs are 0xF and `imm_o` is 0. For class codes 0x0 to 0xB, `valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the first byte of the window |
| win_i | input | 48 | Instruction bytes; byte k on bits [8k+7:8k] |
| op_class_o | output | 4 | Instruction class code |
| op_func_o | output | 4 | Function code |
| reg_a_o | output | 4 | First register specifier, 0xF if absent |
| reg_b_o | output | 4 | Second register specifier, 0xF if absent |
| imm_o | output | 32 | Constant or absolute target, 0 if absent |
| len_o | output | 3 | Instruction length in bytes |
| next_pc_o | output | 32 | Next-sequential program counter |
| valid_o | output | 1 | Class code is defined |

## Verification
Directed windows step through all sixteen class codes. Each one uses a byte 1 and a set of trailing bytes that differ from each other, so the tests can tell whether the constant was taken at offset 1, taken at offset 2, or not taken at all. The same windows show whether a register byte was used or forced to 0xF. The worked example with its little-endian immediate checks the byte order. A program counter just below the 32-bit limit checks the wrap of the sequential address. Seeded random windows and addresses then compare every output against bench functions over many mixed class codes.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int unsigned LEN_W = 3;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_MOVE  = 4'h2;
  localparam logic [3:0] OP_IMM   = 4'h3;
  localparam logic [3:0] OP_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  localparam logic [3:0] REG_NONE = 4'hF;

  typedef struct packed {
    logic             valid;
    logic             has_regs;
    logic             has_const;
    logic             const_at1;  // constant follows the class byte directly
    logic [LEN_W-1:0] len;
  } fmt_t;
endpackage

// File: rtl/ifd_format.sv
module ifd_format
  import ifd_pkg::*;
(
  input  logic [3:0] op_i,
  output fmt_t       fmt_o
);
  always_comb begin
    fmt_o = '{valid: 1'b1, has_regs: 1'b0, has_const: 1'b0, const_at1: 1'b0, len: 3'd1};
    unique case (op_i)
      OP_HALT, OP_NOP, OP_RET: ;
      OP_MOVE, OP_ALU, OP_PUSH, OP_POP: begin
        fmt_o.has_regs = 1'b1;
        fmt_o.len      = 3'd2;
      end
      OP_IMM, OP_STORE, OP_LOAD: begin
        fmt_o.has_regs  = 1'b1;
        fmt_o.has_const = 1'b1;
        fmt_o.len       = 3'd6;
      end
      OP_JUMP, OP_CALL: begin
        fmt_o.has_const = 1'b1;
        fmt_o.const_at1 = 1'b1;
        fmt_o.len       = 3'd5;
      end
      default: fmt_o.valid = 1'b0;
    endcase
  end

  // R7: offset-1 constant only on five-byte forms
  always_comb begin
    a_r7_at1_len5: assert (!fmt_o.const_at1 || (fmt_o.has_const && fmt_o.len == 3'd5));
  end
endmodule

// File: rtl/ifd_fields.sv
module ifd_fields
  import ifd_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 6,
  parameter int unsigned WORD_W    = 32
) (
  input  logic [8*WIN_BYTES-1:0] win_i,
  input  fmt_t                   fmt_i,
  output logic [3:0]             reg_a_o,
  output logic [3:0]             reg_b_o,
  output logic [WORD_W-1:0]      imm_o
);
  localparam int unsigned WORD_BYTES = WORD_W / 8;

  logic [WORD_W-1:0] imm_at1, imm_at2;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
    assign imm_at1[8*k +: 8] = win_i[8*(k+1) +: 8];
    assign imm_at2[8*k +: 8] = win_i[8*(k+2) +: 8];
  end

  always_comb begin
    reg_a_o = fmt_i.has_regs ? win_i[15:12] : REG_NONE;
    reg_b_o = fmt_i.has_regs ? win_i[11:8]  : REG_NONE;
    if (!fmt_i.has_const)   imm_o = '0;
    else if (fmt_i.const_at1) imm_o = imm_at1;
    else                    imm_o = imm_at2;
  end

  // R5 / R8: absent fields are driven to their idle codes
  always_comb begin
    a_r5_regs_absent: assert (fmt_i.has_regs || (reg_a_o == REG_NONE && reg_b_o == REG_NONE));
    a_r8_imm_absent:  assert (fmt_i.has_const || imm_o == '0);
  end
endmodule

// File: rtl/ifd_pc_step.sv
module ifd_pc_step #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 3
) (
  input  logic [WORD_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [WORD_W-1:0] next_pc_o
);
  assign next_pc_o = pc_i + {{(WORD_W-LEN_W){1'b0}}, len_i};
endmodule

// File: rtl/instr_fetch_decode.sv
module instr_fetch_decode
  import ifd_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 6,
  parameter int unsigned WORD_W    = 32
) (
  input  logic [WORD_W-1:0]      pc_i,
  input  logic [8*WIN_BYTES-1:0] win_i,
  output logic [3:0]             op_class_o,
  output logic [3:0]             op_func_o,
  output logic [3:0]             reg_a_o,
  output logic [3:0]             reg_b_o,
  output logic [WORD_W-1:0]      imm_o,
  output logic [LEN_W-1:0]       len_o,
  output logic [WORD_W-1:0]      next_pc_o,
  output logic                   valid_o
);
  fmt_t fmt;

  assign op_class_o = win_i[7:4];
  assign op_func_o  = win_i[3:0];

  ifd_format u_format (
    .op_i  (op_class_o),
    .fmt_o (fmt)
  );

  ifd_fields #(.WIN_BYTES(WIN_BYTES), .WORD_W(WORD_W)) u_fields (
    .win_i   (win_i),
    .fmt_i   (fmt),
    .reg_a_o (reg_a_o),
    .reg_b_o (reg_b_o),
    .imm_o   (imm_o)
  );

  ifd_pc_step #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_pc_step (
    .pc_i      (pc_i),
    .len_i     (fmt.len),
    .next_pc_o (next_pc_o)
  );

  assign len_o   = fmt.len;
  assign valid_o = fmt.valid;

  always_comb begin
    a_r2_len_legal:    assert (len_o == 3'd1 || len_o == 3'd2 || len_o == 3'd5 || len_o == 3'd6);
    a_r3_next_pc:      assert ((next_pc_o - pc_i) == {{(WORD_W-LEN_W){1'b0}}, len_o});
    a_r9_invalid_idle: assert (valid_o || (reg_a_o == REG_NONE && reg_b_o == REG_NONE
                                           && imm_o == '0 && len_o == 3'd1));
  end
endmodule

// File: tb/sim_instr_fetch_decode.sv
module sim_instr_fetch_decode;
  logic        clk = 1'b0;
  logic [31:0] pc;
  logic [47:0] win;
  logic [3:0]  op_class, op_func, reg_a, reg_b;
  logic [31:0] imm, next_pc;
  logic [2:0]  len;
  logic        valid;
  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  instr_fetch_decode u0 (
    .pc_i(pc), .win_i(win), .op_class_o(op_class), .op_func_o(op_func),
    .reg_a_o(reg_a), .reg_b_o(reg_b), .imm_o(imm), .len_o(len),
    .next_pc_o(next_pc), .valid_o(valid)
  );

  function automatic logic [2:0] e_len(input logic [3:0] op);
    case (op)
      4'h2, 4'h6, 4'hA, 4'hB: return 3'd2;
      4'h7, 4'h8:             return 3'd5;
      4'h3, 4'h4, 4'h5:       return 3'd6;
      default:                return 3'd1;
    endcase
  endfunction

  function automatic bit e_regs(input logic [3:0] op);
    return (op >= 4'h2 && op <= 4'h6) || op == 4'hA || op == 4'hB;
  endfunction

  function automatic logic [31:0] e_imm(input logic [47:0] w);
    logic [3:0] op = w[7:4];
    if (op >= 4'h3 && op <= 4'h5) return {w[47:40], w[39:32], w[31:24], w[23:16]};
    if (op == 4'h7 || op == 4'h8) return {w[39:32], w[31:24], w[23:16], w[15:8]};
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h win=%h pc=%h", tag, act, exp, win, pc);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [47:0] w);
    logic [3:0] op;
    @(posedge clk);
    pc  = p;
    win = w;
    @(negedge clk);
    op = w[7:4];
    chk(op_class == op && op_func == w[3:0], "R1", {op_class, op_func}, {24'h0, w[7:0]});
    chk(len == e_len(op), "R2", 32'(len), 32'(e_len(op)));
    chk(next_pc == p + 32'(e_len(op)), "R3", next_pc, p + 32'(e_len(op)));
    if (e_regs(op)) begin
      chk(reg_a == w[15:12], "R4 reg_a", 32'(reg_a), 32'(w[15:12]));
      chk(reg_b == w[11:8],  "R4 reg_b", 32'(reg_b), 32'(w[11:8]));
    end else begin
      chk(reg_a == 4'hF && reg_b == 4'hF, op >= 4'hC ? "R9 regs" : "R5",
          {24'h0, reg_a, reg_b}, 32'hFF);
    end
    if (op >= 4'h3 && op <= 4'h5)      chk(imm == e_imm(w), "R6", imm, e_imm(w));
    else if (op == 4'h7 || op == 4'h8) chk(imm == e_imm(w), "R7", imm, e_imm(w));
    else                               chk(imm == 32'h0, "R8", imm, 32'h0);
    chk(valid == (op < 4'hC), "R9 valid", 32'(valid), 32'(op < 4'hC));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    pc  = 32'h0;
    win = 48'h0;
    // idle window: halt with zero bytes
    apply(32'h0, 48'h0);
    // R6 worked example: 30 F2 cd ab 00 00
    apply(32'h100, 48'h0000_abcd_f230);
    chk(imm == 32'h0000abcd && reg_b == 4'h2 && reg_a == 4'hF, "R6 example",
        imm, 32'h0000abcd);
    // every class with distinct trailing bytes so offset 1 and 2 differ
    for (int op = 0; op < 16; op++)
      apply(32'h1000 + 32'(op), {8'h66, 8'h55, 8'h44, 8'h33, 8'h7E, 4'(op), 4'h5});
    // R3 wrap near the top of the address space
    apply(32'hFFFF_FFFE, 48'h1122_3344_5530);  // 6 bytes
    chk(next_pc == 32'h4, "R3 wrap", next_pc, 32'h4);
    apply(32'hFFFF_FFFF, 48'h0000_0000_0090);  // 1 byte
    chk(next_pc == 32'h0, "R3 wrap", next_pc, 32'h0);
    // R5 register byte ignored for jump even when it looks like registers
    apply(32'h20, 48'hAAAA_AAAA_1270);
    chk(reg_a == 4'hF && reg_b == 4'hF, "R5 jump", {reg_a, reg_b}, 8'hFF);
    // random mix
    for (int i = 0; i < 600; i++)
      apply($urandom, {16'($urandom), $urandom});
    finish_run();
  end
endmodule